// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into 8-bit or 9-bit characters. The line rests at 1. A frame opens with a 0 start bit, carries its data bits least significant bit first, and closes with a 1 stop bit. An external rate generator supplies a single-cycle pulse at sixteen times the bit rate. The receiver uses these pulses to locate the middle of each bit and votes over three samples there. Finished characters go into a two-entry first-in first-out store. Each entry keeps its framing status, and the consumer removes the oldest entry with a one-cycle pop strobe.

A port enable resets the entire block while it is low. A receive enable must be high for reception to take place. An overrun is sticky and blocks further input until the receive enable is dropped. In 9-bit mode, an optional address filter keeps only characters whose ninth bit is 1. Status outputs report whether the buffer holds data, whether an overrun has occurred, and whether the line is idle.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rx_idle is 1 and both data_avail and overrun are 0. Holding port_en low for one cycle empties the buffer, clears overrun and returns the receiver to idle.
- R2: With nine_bit=0, a frame carries 8 data bits, least significant bit first. The character appears on rd_data[7:0] with rd_data[8]=0.
- R3: With nine_bit=1, a frame carries 9 data bits, least significant bit first. The ninth received bit appears on rd_data[8].
- R4: The buffer holds up to two characters and returns them in arrival order. data_avail is 1 while at least one character is held. A pulse on pop removes the character shown on rd_data.
- R5: A character that completes while the buffer already holds two sets overrun and is discarded. While overrun is 1, every further character is discarded and overrun stays 1.
- R6: When rx_en is 0, overrun is cleared and no character is received. Characters already in the buffer are kept.
- R7: A stop bit that samples as 0 stores its character with rd_ferr=1, and a good stop bit stores rd_ferr=0. rd_ferr follows the character at the head of the buffer. After a framing error, the receiver waits for the line to return to 1 before it looks for another start bit.
- R8: With nine_bit=1 and addr_filt=1, a character whose ninth bit is 0 is discarded. With nine_bit=0, addr_filt has no effect.
- R9: rx_idle goes to 0 when a start bit is detected and stays 0 until the stop bit has been sampled.
- R10: A start bit that samples as 1 at its middle is rejected. The receiver returns to idle and stores nothing.
- R11: Each bit is decided by a majority of three samples taken on consecutive ticks around the bit centre, so a disturbance that covers a single tick does not alter the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_16x | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line, asynchronous to clk |
| port_en | input | 1 | Port enable; low resets the block |
| rx_en | input | 1 | Receive enable; low also clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| addr_filt | input | 1 | Keep only characters with ninth bit 1 (9-bit mode) |
| pop | input | 1 | Remove the head character |
| rd_data | output | 9 | Head character |
| rd_ferr | output | 1 | Framing error of the head character |
| data_avail | output | 1 | Buffer holds at least one character |
| overrun | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No frame in progress |

## Verification
Random characters are sent in both data widths, with random filter settings and occasional bad stop bits. Some are read one at a time and some arrive in pairs before reading. This separates bit ordering and ninth-bit placement faults from errors in buffer order and status tracking. Directed frames cover the remaining cases: a third and a fourth character against a full buffer, a frame sent while rx_en is low, a port_en drop with data held, a short false start, and a single-tick disturbance at a bit centre. These show whether the sticky overrun, the enable handling, start rejection and the three-sample vote behave as specified.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the serial receiver.
// Assumes nothing beyond standard SystemVerilog.
package uart_rx_pkg;

    // Receiver frame phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three vote over samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes the line rests high; the flops reset to 1 so no false start appears.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
// Frame engine: finds the start bit, times each bit with the oversample
// tick, votes over three centre samples and assembles the character.
// Assumes OSR >= 8 and that nine_bit is steady during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        tick,
    input  logic        rx_s,
    input  logic        nine_bit,
    output logic        busy,
    output logic        done,
    output logic        stop_bad,
    output logic [DW:0] char_out
);

    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW + 1);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] SMP_A = CW'(MID - 2);
    localparam logic [CW-1:0] SMP_B = CW'(MID - 1);
    localparam logic [CW-1:0] SMP_C = CW'(MID);
    localparam logic [CW-1:0] CNT_END = CW'(OSR - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic          s_a, s_b, armed;
    logic [DW:0]   shreg;
    logic          maj;
    logic [BW-1:0] last_bit;

    assign maj      = vote3(s_a, s_b, rx_s);
    assign last_bit = nine_bit ? BW'(DW) : BW'(DW - 1);

    // Sequence the frame phases on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bitn     <= '0;
            s_a      <= 1'b1;
            s_b      <= 1'b1;
            armed    <= 1'b0;
            shreg    <= '0;
            done     <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == ST_IDLE) begin
                if (rx_s) begin
                    armed <= 1'b1;
                end else if (tick && armed) begin
                    state <= ST_START;
                    cnt   <= '0;
                    armed <= 1'b0;
                end
            end else if (tick) begin
                cnt <= (cnt == CNT_END) ? '0 : cnt + 1'b1;
                if (cnt == SMP_A) s_a <= rx_s;
                if (cnt == SMP_B) s_b <= rx_s;
                if (cnt == SMP_C) begin
                    case (state)
                        ST_START: if (maj) state <= ST_IDLE;
                        ST_DATA:  shreg <= {maj, shreg[DW:1]};
                        ST_STOP: begin
                            done     <= 1'b1;
                            stop_bad <= ~maj;
                            state    <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (cnt == CNT_END) begin
                    case (state)
                        ST_START: begin
                            state <= ST_DATA;
                            bitn  <= '0;
                        end
                        ST_DATA: begin
                            if (bitn == last_bit) state <= ST_STOP;
                            else                  bitn  <= bitn + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign char_out = nine_bit ? shreg : {1'b0, shreg[DW:1]};

endmodule

// File: rtl/uart_rx_fifo.sv
// Small first-in first-out store for received characters.
// Assumes push is a single-cycle strobe; a push into a full store is
// accepted only when a pop frees a slot in the same cycle.
module uart_rx_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 10,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] PTR_END = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          do_pop, do_push;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Write one storage entry per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PW'(g)) mem[g] <= din;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: ;
            endcase
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/uart_rx_core.sv
// Top of the asynchronous serial receiver: synchronizer, frame engine,
// address filter, overrun control and character store.
// Assumes tick_16x is a one-cycle pulse at OSR times the bit rate.
module uart_rx_core #(
    parameter int OSR   = 16,
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_16x,
    input  logic          rx_in,
    input  logic          port_en,
    input  logic          rx_en,
    input  logic          nine_bit,
    input  logic          addr_filt,
    input  logic          pop,
    output logic [DW:0]   rd_data,
    output logic          rd_ferr,
    output logic          data_avail,
    output logic          overrun,
    output logic          rx_idle
);

    localparam int LW = $clog2(DEPTH + 1);

    logic          core_rst_n;
    logic          rx_s, busy, done, stop_bad;
    logic [DW:0]   char_w;
    logic          addr_ok, want, push_v, buf_empty, buf_full;
    logic [DW+1:0] buf_out;
    logic [LW-1:0] buf_level;

    assign core_rst_n = rst_n & port_en;

    uart_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(core_rst_n), .din(rx_in), .dout(rx_s)
    );

    uart_rx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk(clk), .rst_n(core_rst_n), .clr(~rx_en), .tick(tick_16x),
        .rx_s(rx_s), .nine_bit(nine_bit), .busy(busy), .done(done),
        .stop_bad(stop_bad), .char_out(char_w)
    );

    assign addr_ok = !(nine_bit && addr_filt && !char_w[DW]);
    assign want    = done && addr_ok && !overrun;
    assign push_v  = want && (!buf_full || pop);

    // Hold overrun until the receive enable drops.
    always_ff @(posedge clk) begin
        if (!core_rst_n || !rx_en) begin
            overrun <= 1'b0;
        end else if (want && buf_full && !pop) begin
            overrun <= 1'b1;
        end
    end

    uart_rx_fifo #(.DEPTH(DEPTH), .W(DW + 2), .LW(LW)) u_fifo (
        .clk(clk), .rst_n(core_rst_n), .push(push_v),
        .din({stop_bad, char_w}), .pop(pop), .dout(buf_out),
        .empty(buf_empty), .full(buf_full), .level(buf_level)
    );

    assign rd_data    = buf_out[DW:0];
    assign rd_ferr    = buf_out[DW+1];
    assign data_avail = !buf_empty;
    assign rx_idle    = !busy;

endmodule

// File: rtl/uart_rx_chk.sv
// Property checker for the serial receiver, bound to the top module.
// Assumes it observes the top's ports and its buffer occupancy.
module uart_rx_chk #(
    parameter int DEPTH = 2,
    parameter int LW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_en,
    input logic          rx_en,
    input logic          overrun,
    input logic          data_avail,
    input logic          rx_idle,
    input logic [LW-1:0] level
);

    // Port disable clears state on the next cycle.
    assert_port_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!data_avail && !overrun && rx_idle));

    // Occupancy never passes the buffer depth.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // Overrun only rises against a full buffer.
    assert_ovr_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(level) == LW'(DEPTH));

    // Overrun stays set while both enables are high.
    assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en && port_en) |=> overrun);

    // Dropping the receive enable clears overrun.
    assert_ovr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !overrun);

endmodule

bind uart_rx_core uart_rx_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
    .overrun(overrun), .data_avail(data_avail), .rx_idle(rx_idle),
    .level(buf_level)
);

// File: tb/uart_rx_core_tb.sv
// Bench: serial line model, seeded random frames plus directed corners.
module uart_rx_core_tb;

    localparam int BIT_CLKS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic rx_line = 1'b1;
    logic port_en = 1'b1, rx_en = 1'b1, nine = 1'b0, af = 1'b0, pop = 1'b0;
    logic [8:0] rd_data;
    logic rd_ferr, data_avail, overrun, rx_idle;

    int checks = 0, errors = 0;
    logic [8:0] m_d [2];
    logic       m_f [2];
    int         m_n = 0;
    logic       m_ovr = 1'b0;

    always #5 clk = ~clk;

    // Oversample tick: one pulse every four clocks.
    always_ff @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    uart_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick), .rx_in(rx_line),
        .port_en(port_en), .rx_en(rx_en), .nine_bit(nine), .addr_filt(af),
        .pop(pop), .rd_data(rd_data), .rd_ferr(rd_ferr),
        .data_avail(data_avail), .overrun(overrun), .rx_idle(rx_idle)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected receiver behaviour for one completed frame.
    task automatic model_rx(input logic [8:0] d, input logic ferr);
        logic [8:0] ed;
        ed = nine ? d : {1'b0, d[7:0]};
        if (!rx_en || m_ovr) return;
        if (nine && af && !ed[8]) return;
        if (m_n == 2) begin
            m_ovr = 1'b1;
        end else begin
            m_d[m_n] = ed;
            m_f[m_n] = ferr;
            m_n++;
        end
    endtask

    // Drive one frame; gbit inverts one tick-long slice at a data bit centre.
    task automatic send(input logic [8:0] d, input logic stopv, input int gbit);
        int nb;
        nb = nine ? 9 : 8;
        @(negedge clk);
        rx_line = 1'b0;
        repeat (32) @(negedge clk);
        if (rx_en) chk(rx_idle == 1'b0, "R9 busy in frame", 32'(rx_idle), 0);
        repeat (BIT_CLKS - 32) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            for (int c = 0; c < BIT_CLKS; c++) begin
                rx_line = (i == gbit && c >= 30 && c < 34) ? ~d[i] : d[i];
                @(negedge clk);
            end
        end
        rx_line = stopv;
        repeat (BIT_CLKS) @(negedge clk);
        rx_line = 1'b1;
        repeat (32) @(negedge clk);
        model_rx(d, ~stopv);
        chk(overrun == m_ovr, "R5 overrun flag", 32'(overrun), 32'(m_ovr));
        chk(rx_idle == 1'b1, "R9 idle after frame", 32'(rx_idle), 1);
    endtask

    // Read out everything the model holds and compare.
    task automatic drain();
        while (m_n > 0) begin
            @(negedge clk);
            chk(data_avail == 1'b1, "R4 data_avail", 32'(data_avail), 1);
            chk(rd_data == m_d[0], nine ? "R3 char" : "R2 char", 32'(rd_data), 32'(m_d[0]));
            chk(rd_ferr == m_f[0], "R7 ferr", 32'(rd_ferr), 32'(m_f[0]));
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
            m_d[0] = m_d[1];
            m_f[0] = m_f[1];
            m_n--;
        end
        @(negedge clk);
        chk(data_avail == 1'b0, "R4 empty after reads", 32'(data_avail), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(rx_idle == 1'b1, "R1 reset idle", 32'(rx_idle), 1);
        chk(data_avail == 1'b0, "R1 reset empty", 32'(data_avail), 0);
        chk(overrun == 1'b0, "R1 reset overrun", 32'(overrun), 0);

        // R2: 8-bit characters
        send(9'h0A5, 1'b1, -1);
        send(9'h03C, 1'b1, -1);
        drain();
        // R3: 9-bit character with ninth bit set
        nine = 1'b1;
        send(9'h1C3, 1'b1, -1);
        drain();
        // R7: bad stop then good stop
        nine = 1'b0;
        send(9'h05A, 1'b0, -1);
        send(9'h081, 1'b1, -1);
        drain();
        // R8: filter in 9-bit mode, then ignored in 8-bit mode
        nine = 1'b1; af = 1'b1;
        send(9'h055, 1'b1, -1);
        @(negedge clk);
        chk(data_avail == 1'b0, "R8 address filtered", 32'(data_avail), 0);
        send(9'h1AA, 1'b1, -1);
        drain();
        nine = 1'b0;
        send(9'h077, 1'b1, -1);
        drain();
        af = 1'b0;
        // R10: short false start
        @(negedge clk);
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
        chk(rx_idle == 1'b1, "R10 glitch idle", 32'(rx_idle), 1);
        chk(data_avail == 1'b0, "R10 glitch stored nothing", 32'(data_avail), 0);
        send(9'h0E7, 1'b1, -1);
        drain();
        // R11: single-tick disturbance at bit centres
        send(9'h0F0, 1'b1, 3);
        send(9'h00F, 1'b1, 0);
        drain();
        // R5: overrun and discard while set
        send(9'h011, 1'b1, -1);
        send(9'h022, 1'b1, -1);
        send(9'h033, 1'b1, -1);
        send(9'h044, 1'b1, -1);
        // R6: receive disabled clears overrun and ignores the line
        @(negedge clk);
        rx_en = 1'b0;
        m_ovr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(overrun == 1'b0, "R6 overrun cleared", 32'(overrun), 0);
        send(9'h055, 1'b1, -1);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        drain();
        // R1: port disable empties buffer
        send(9'h066, 1'b1, -1);
        chk(data_avail == 1'b1, "R1 char held", 32'(data_avail), 1);
        port_en = 1'b0;
        repeat (2) @(negedge clk);
        port_en = 1'b1;
        m_n = 0;
        m_ovr = 1'b0;
        repeat (4) @(negedge clk);
        chk(data_avail == 1'b0, "R1 port disable empties", 32'(data_avail), 0);
        chk(rx_idle == 1'b1, "R1 port disable idle", 32'(rx_idle), 1);

        // Seeded random frames.
        for (int k = 0; k < 30; k++) begin
            logic [8:0] d;
            logic sv;
            int g, nfr;
            nine = 1'($urandom % 2);
            af   = 1'($urandom % 2);
            nfr  = (($urandom % 3) == 0) ? 2 : 1;
            for (int f = 0; f < nfr; f++) begin
                d  = 9'($urandom);
                sv = (($urandom % 6) != 0);
                g  = (($urandom % 2) == 0) ? -1 : int'($urandom % 8);
                send(d, sv, g);
            end
            drain();
        end

        summary();
        $finish;
    end

endmodule